// File: doc/BRIEF.md
# Prioritized Trap Interrupt Controller

This block holds the pending interrupt state for one processor thread. The state is seven classes of 64-bit pending vectors, plus one summary bit per class. Requesters set or clear single bits through a post port and a clear port. Each request names a class and a bit index. A flush input wipes all state in one cycle. Reset does the same.

Every cycle the block picks at most one interrupt to take. The pick depends on the pending classes, a hyper-privileged mode flag and an interrupt-enable flag. The result is a trap kind code, a valid flag and, for software interrupts, a 4-bit level. A combinational read port returns the whole pending vector of any class.

Post and clear carry no payload stream. The block always accepts them, so neither port has back-pressure. The chosen trap is a status output that is recomputed every cycle. There is no handshake on it.

Top module: `trap_irq_ctrl`

## Requirements
- R1: A post with a class number from 0 to 6 sets bit `index` of that class's vector and sets the class's summary bit. Both are visible from the cycle after the request.
- R2: A clear removes bit `index` from the named class's vector. The class's summary bit falls only when that vector has become all zero.
- R3: Reset and `flush_i` zero every vector and the summary bits. `flush_i` overrides any post or clear in the same cycle.
- R4: `any_pend_o` is high exactly when some summary bit is set, whatever the values of `hpriv_i` and `ie_i`.
- R5: With `hpriv_i` high, nothing is taken while `ie_i` is low. With `ie_i` high, class 1 is taken first, then class 2, and no other class is considered.
- R6: With `hpriv_i` low, the order is class 0, then class 1, then class 2, and these three do not depend on `ie_i`. Only when `ie_i` is high are classes 3, 4, 5 and 6 considered, in that order.
- R7: When class 5 is taken, `soft_lvl_o` is 14 if bit 16 or bit 0 of its vector is set. Otherwise it is the index of the highest set bit among bits 15 down to 1, or 0 if none of those is set. When another kind is taken, or nothing is, `soft_lvl_o` is 0.
- R8: `take_kind_o` is 0 when nothing is taken and class number + 1 otherwise. `take_valid_o` is high exactly when the code is non-zero.
- R9: A post and a clear to the same class and bit in the same cycle leave that bit cleared.
- R10: A post or clear with class number 7 changes no state.
- R11: `rd_vec_o` returns, in the same cycle, the vector of class `rd_cls_i`. It returns zero for class number 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all pending state |
| post_en_i | input | 1 | Post request strobe |
| post_cls_i | input | 3 | Class number of post |
| post_idx_i | input | 6 | Bit index of post |
| clr_en_i | input | 1 | Clear request strobe |
| clr_cls_i | input | 3 | Class number of clear |
| clr_idx_i | input | 6 | Bit index of clear |
| hpriv_i | input | 1 | Hyper-privileged mode flag |
| ie_i | input | 1 | Interrupt-enable flag |
| rd_cls_i | input | 3 | Class selected for read-back |
| rd_vec_o | output | 64 | Pending vector of the selected class |
| any_pend_o | output | 1 | Some class is pending |
| take_valid_o | output | 1 | An interrupt is chosen |
| take_kind_o | output | 3 | Chosen trap kind code |
| soft_lvl_o | output | 4 | Software interrupt level |

## Verification
A post and a clear can fall in the same cycle, and so can a flush. They may hit the same class and bit, the same class with different bits, or different classes. The random stimulus draws the class and index of both ports from a narrow pool, so overlaps are frequent. Directed steps force the exact same-bit case and a flush together with a post. Each outcome is judged against a bench model that applies the post, then the clear, then the flush. The vector read port and the chosen trap are compared one cycle later.

// File: rtl/trap_irq_pkg.sv
`timescale 1ns/1ps
package trap_irq_pkg;
  localparam int NUM_CLS = 7;
  localparam int CLS_W   = 3;
  localparam int KIND_W  = 3;
  localparam int LVL_W   = 4;

  localparam int C_TLZ    = 0;
  localparam int C_TMATCH = 1;
  localparam int C_IVEC   = 2;
  localparam int C_CPUM   = 3;
  localparam int C_DEVM   = 4;
  localparam int C_SOFT   = 5;
  localparam int C_RESERR = 6;

  typedef enum logic [KIND_W-1:0] {
    K_NONE   = 3'd0,
    K_TLZ    = 3'd1,
    K_TMATCH = 3'd2,
    K_IVEC   = 3'd3,
    K_CPUM   = 3'd4,
    K_DEVM   = 3'd5,
    K_SOFT   = 3'd6,
    K_RESERR = 3'd7
  } trap_kind_e;
endpackage

// File: rtl/trap_class_store.sv
`timescale 1ns/1ps
module trap_class_store
  import trap_irq_pkg::*;
#(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush_i,
  input  logic                          post_en_i,
  input  logic [CLS_W-1:0]              post_cls_i,
  input  logic [IDX_W-1:0]              post_idx_i,
  input  logic                          clr_en_i,
  input  logic [CLS_W-1:0]              clr_cls_i,
  input  logic [IDX_W-1:0]              clr_idx_i,
  output logic [NUM_CLS-1:0][VEC_W-1:0] vec_o,
  output logic [NUM_CLS-1:0]            sum_o
);
  localparam logic [VEC_W-1:0] ONE = {{(VEC_W-1){1'b0}}, 1'b1};

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic             post_hit, clr_hit;
    logic [VEC_W-1:0] set_m, clr_m, nxt, v_q;
    logic             s_q;

    always_comb begin
      post_hit = post_en_i && (post_cls_i == CLS_W'(c));
      clr_hit  = clr_en_i  && (clr_cls_i  == CLS_W'(c));
      set_m    = post_hit ? (ONE << post_idx_i) : '0;
      clr_m    = clr_hit  ? (ONE << clr_idx_i)  : '0;
      // clear applied after set: same-bit collision ends cleared
      nxt      = (v_q | set_m) & ~clr_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        s_q <= 1'b0;
      end else if (flush_i) begin
        v_q <= '0;
        s_q <= 1'b0;
      end else if (post_hit || clr_hit) begin
        v_q <= nxt;
        s_q <= |nxt;
      end
    end

    assign vec_o[c] = v_q;
    assign sum_o[c] = s_q;
  end
endmodule

// File: rtl/trap_soft_level.sv
`timescale 1ns/1ps
module trap_soft_level
  import trap_irq_pkg::*;
#(
  parameter int VEC_W    = 64,
  parameter int HI_BIT   = 15,
  parameter int ALIAS_HI = 16,
  parameter int ALIAS_LV = 14
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 1; i <= HI_BIT; i++) begin
      if (vec_i[i]) lvl_o = LVL_W'(i);
    end
    if (vec_i[ALIAS_HI] || vec_i[0]) lvl_o = LVL_W'(ALIAS_LV);
  end
endmodule

// File: rtl/trap_selector.sv
`timescale 1ns/1ps
module trap_selector
  import trap_irq_pkg::*;
(
  input  logic [NUM_CLS-1:0] sum_i,
  input  logic               hpriv_i,
  input  logic               ie_i,
  output trap_kind_e         kind_o
);
  always_comb begin
    kind_o = K_NONE;
    if (hpriv_i) begin
      if (ie_i) begin
        if      (sum_i[C_TMATCH]) kind_o = K_TMATCH;
        else if (sum_i[C_IVEC])   kind_o = K_IVEC;
      end
    end else begin
      if      (sum_i[C_TLZ])              kind_o = K_TLZ;
      else if (sum_i[C_TMATCH])           kind_o = K_TMATCH;
      else if (sum_i[C_IVEC])             kind_o = K_IVEC;
      else if (ie_i && sum_i[C_CPUM])     kind_o = K_CPUM;
      else if (ie_i && sum_i[C_DEVM])     kind_o = K_DEVM;
      else if (ie_i && sum_i[C_SOFT])     kind_o = K_SOFT;
      else if (ie_i && sum_i[C_RESERR])   kind_o = K_RESERR;
    end
  end
endmodule

// File: rtl/trap_irq_ctrl.sv
`timescale 1ns/1ps
module trap_irq_ctrl
  import trap_irq_pkg::*;
#(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              post_en_i,
  input  logic [CLS_W-1:0]  post_cls_i,
  input  logic [IDX_W-1:0]  post_idx_i,
  input  logic              clr_en_i,
  input  logic [CLS_W-1:0]  clr_cls_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic              hpriv_i,
  input  logic              ie_i,
  input  logic [CLS_W-1:0]  rd_cls_i,
  output logic [VEC_W-1:0]  rd_vec_o,
  output logic              any_pend_o,
  output logic              take_valid_o,
  output logic [KIND_W-1:0] take_kind_o,
  output logic [LVL_W-1:0]  soft_lvl_o
);
  logic [NUM_CLS-1:0][VEC_W-1:0] vec;
  logic [NUM_CLS*VEC_W-1:0]      vec_flat;
  logic [NUM_CLS-1:0]            sum_q;
  logic [LVL_W-1:0]              lvl_raw;
  trap_kind_e                    kind;

  trap_class_store #(.VEC_W(VEC_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .post_en_i  (post_en_i),
    .post_cls_i (post_cls_i),
    .post_idx_i (post_idx_i),
    .clr_en_i   (clr_en_i),
    .clr_cls_i  (clr_cls_i),
    .clr_idx_i  (clr_idx_i),
    .vec_o      (vec),
    .sum_o      (sum_q)
  );

  trap_soft_level #(.VEC_W(VEC_W)) lvl_i (
    .vec_i (vec[C_SOFT]),
    .lvl_o (lvl_raw)
  );

  trap_selector sel_i (
    .sum_i   (sum_q),
    .hpriv_i (hpriv_i),
    .ie_i    (ie_i),
    .kind_o  (kind)
  );

  assign vec_flat = vec;

  always_comb begin
    rd_vec_o = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (rd_cls_i == CLS_W'(c)) rd_vec_o = vec[c];
    end
  end

  assign any_pend_o   = |sum_q;
  assign take_kind_o  = kind;
  assign take_valid_o = (kind != K_NONE);
  assign soft_lvl_o   = (kind == K_SOFT) ? lvl_raw : '0;
endmodule

// File: rtl/trap_irq_ctrl_chk.sv
`timescale 1ns/1ps
module trap_irq_ctrl_chk
  import trap_irq_pkg::*;
#(
  parameter int VEC_W = 64,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush_i,
  input logic                     post_en_i,
  input logic [CLS_W-1:0]         post_cls_i,
  input logic [IDX_W-1:0]         post_idx_i,
  input logic                     clr_en_i,
  input logic [CLS_W-1:0]         clr_cls_i,
  input logic [IDX_W-1:0]         clr_idx_i,
  input logic                     hpriv_i,
  input logic                     ie_i,
  input logic                     any_pend_o,
  input logic                     take_valid_o,
  input logic [KIND_W-1:0]        take_kind_o,
  input logic [LVL_W-1:0]         soft_lvl_o,
  input logic [NUM_CLS*VEC_W-1:0] vec_flat,
  input logic [NUM_CLS-1:0]       sum_q
);
  function automatic logic [NUM_CLS-1:0] or_each(input logic [NUM_CLS*VEC_W-1:0] v);
    logic [NUM_CLS-1:0] r;
    for (int c = 0; c < NUM_CLS; c++) r[c] = |v[c*VEC_W +: VEC_W];
    return r;
  endfunction

  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en_i && int'(post_cls_i) < NUM_CLS && !flush_i &&
     !(clr_en_i && clr_cls_i == post_cls_i && clr_idx_i == post_idx_i))
    |=> (vec_flat[int'($past(post_cls_i))*VEC_W + int'($past(post_idx_i))] &&
         sum_q[$past(post_cls_i)]));

  p_clear_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && int'(clr_cls_i) < NUM_CLS)
    |=> !vec_flat[int'($past(clr_cls_i))*VEC_W + int'($past(clr_idx_i))]);

  p_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q == or_each(vec_flat));

  p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vec_flat == '0 && sum_q == '0));

  p_take_implies_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o |-> any_pend_o);

  p_hpriv_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hpriv_i && !ie_i) |-> !take_valid_o);

  p_hpriv_kinds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hpriv_i |-> (take_kind_o == K_NONE || take_kind_o == K_TMATCH ||
                 take_kind_o == K_IVEC));

  p_low_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |-> (take_kind_o <= K_IVEC));

  p_lvl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_kind_o != K_SOFT) |-> (soft_lvl_o == '0));

  p_bad_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && (!post_en_i || int'(post_cls_i) >= NUM_CLS) &&
     (!clr_en_i || int'(clr_cls_i) >= NUM_CLS))
    |=> vec_flat == $past(vec_flat));
endmodule

bind trap_irq_ctrl trap_irq_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .post_en_i    (post_en_i),
  .post_cls_i   (post_cls_i),
  .post_idx_i   (post_idx_i),
  .clr_en_i     (clr_en_i),
  .clr_cls_i    (clr_cls_i),
  .clr_idx_i    (clr_idx_i),
  .hpriv_i      (hpriv_i),
  .ie_i         (ie_i),
  .any_pend_o   (any_pend_o),
  .take_valid_o (take_valid_o),
  .take_kind_o  (take_kind_o),
  .soft_lvl_o   (soft_lvl_o),
  .vec_flat     (vec_flat),
  .sum_q        (sum_q)
);

// File: tb/trap_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module trap_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        post_en_i = 1'b0;
  logic [2:0]  post_cls_i = '0;
  logic [5:0]  post_idx_i = '0;
  logic        clr_en_i = 1'b0;
  logic [2:0]  clr_cls_i = '0;
  logic [5:0]  clr_idx_i = '0;
  logic        hpriv_i = 1'b0;
  logic        ie_i = 1'b0;
  logic [2:0]  rd_cls_i = '0;
  logic [63:0] rd_vec_o;
  logic        any_pend_o, take_valid_o;
  logic [2:0]  take_kind_o;
  logic [3:0]  soft_lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] m_vec [0:6];

  always #5 clk = ~clk;

  trap_irq_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_lvl(input logic [63:0] v);
    logic [3:0] l = 0;
    if (v[16] || v[0]) return 4'd14;
    for (int i = 15; i >= 1; i--) if (v[i]) return 4'(i);
    return l;
  endfunction

  function automatic logic [2:0] exp_kind(input bit hp, input bit ie);
    if (hp) begin
      if (!ie) return 3'd0;
      if (m_vec[1] != 0) return 3'd2;
      if (m_vec[2] != 0) return 3'd3;
      return 3'd0;
    end
    for (int c = 0; c < 3; c++) if (m_vec[c] != 0) return 3'(c + 1);
    if (ie) for (int c = 3; c < 7; c++) if (m_vec[c] != 0) return 3'(c + 1);
    return 3'd0;
  endfunction

  // drive at negedge, check current state, then advance the model
  task automatic step(input string note, input bit pe, input int pc, input int pi,
                      input bit ce, input int cc, input int ci, input bit fl,
                      input bit hp, input bit ie, input int rc);
    logic [2:0] k;
    logic       any;
    @(negedge clk);
    post_en_i = pe; post_cls_i = 3'(pc); post_idx_i = 6'(pi);
    clr_en_i = ce;  clr_cls_i = 3'(cc);  clr_idx_i = 6'(ci);
    flush_i = fl; hpriv_i = hp; ie_i = ie; rd_cls_i = 3'(rc);
    #1;
    k = exp_kind(hp, ie);
    any = 1'b0;
    for (int c = 0; c < 7; c++) if (m_vec[c] != 0) any = 1'b1;
    chk({note, hp ? " R5 kind" : " R6 kind"}, 64'(take_kind_o), 64'(k));
    chk({note, " R8 valid"}, 64'(take_valid_o), 64'(k != 0));
    chk({note, " R7 level"}, 64'(soft_lvl_o), 64'((k == 3'd6) ? exp_lvl(m_vec[5]) : 4'd0));
    chk({note, " R4 any"}, 64'(any_pend_o), 64'(any));
    chk({note, " R11 read"}, rd_vec_o, (rc < 7) ? m_vec[rc] : 64'd0);
    // model: post, then clear (R9), then flush (R3); class 7 ignored (R10)
    if (pe && pc < 7) m_vec[pc][pi] = 1'b1;
    if (ce && cc < 7) m_vec[cc][ci] = 1'b0;
    if (fl) for (int c = 0; c < 7; c++) m_vec[c] = '0;
  endtask

  function automatic int pick_idx();
    case ($urandom % 4)
      0: return 0;
      1: return 16;
      2: return int'($urandom % 17);
      default: return int'($urandom % 64);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 7; c++) m_vec[c] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 reset kind", 64'(take_kind_o), 64'd0);
    chk("R3 reset any", 64'(any_pend_o), 64'd0);
    rst_n = 1'b1;
    step("R3 after reset", 0,0,0, 0,0,0, 0, 0,1, 5);
    step("R1 post soft16", 1,5,16, 0,0,0, 0, 0,1, 5);
    step("R1 R7 bit16 gives 14", 0,0,0, 0,0,0, 0, 0,1, 5);
    step("R2 clr16 post9", 1,5,9, 1,5,16, 0, 0,1, 5);
    step("R7 highest bit 9", 1,5,0, 0,0,0, 0, 0,1, 5);
    step("R7 bit0 gives 14", 0,0,0, 1,5,0, 0, 0,1, 5);
    step("R2 summary held", 0,0,0, 1,5,9, 0, 0,1, 5);
    step("R2 summary dropped", 1,5,40, 0,0,0, 0, 0,1, 5);
    step("R7 upper bit gives 0", 1,6,3, 0,0,0, 0, 0,1, 5);
    step("R6 enable gating", 0,0,0, 0,0,0, 0, 0,0, 6);
    step("R6 soft over reserr", 1,0,5, 0,0,0, 0, 0,1, 6);
    step("R5 tlz ignored in hpriv", 0,0,0, 0,0,0, 0, 1,1, 0);
    step("R6 tlz without enable", 1,1,63, 0,0,0, 0, 0,0, 0);
    step("R5 R4 hpriv disabled", 0,0,0, 0,0,0, 0, 1,0, 1);
    step("R5 tmatch in hpriv", 1,2,7, 1,2,7, 0, 1,1, 1);
    step("R9 same bit clear wins", 1,7,1, 1,7,1, 0, 0,1, 2);
    step("R10 class 7 ignored", 0,0,0, 0,0,0, 0, 0,1, 7);
    step("R3 flush with post", 1,3,2, 0,0,0, 1, 0,1, 3);
    step("R3 after flush", 0,0,0, 0,0,0, 0, 0,1, 3);
    for (int n = 0; n < 3000; n++) begin
      step("rand", bit'($urandom % 2), int'($urandom % 8), pick_idx(),
           bit'($urandom % 2), int'($urandom % 8), pick_idx(),
           bit'(($urandom % 50) == 0), bit'($urandom % 2),
           bit'($urandom % 4 != 0), int'($urandom % 8));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule